// File: doc/BRIEF.md
# Byte Table Lookup Unit

The unit builds a 64-bit result from eight independent 8-bit indices. Each index picks one byte out of a small table of 64-bit table words, presented as a single flattened input vector. A 2-bit length field sets how many table words are live: one, two, three or four. When an index points past the end of the live table, that result lane takes the byte in the same lane of a separate default word instead of being zeroed.

A request is offered with `in_valid`. It is taken when `in_ready` is high. The looked-up word is captured in a result register and announced by a single-cycle `out_valid` pulse in the cycle after acceptance. The control is a two-state machine. In state IDLE, `in_ready` is high, and a request moves it to RESP (transition ACCEPT). RESP lasts one cycle, with `out_valid` high and `in_ready` low, and then returns to IDLE (transition RETIRE). While in IDLE with no request, it stays put (transition WAIT). Reset puts the machine in IDLE.

Top module: `byte_tbl_lookup`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `out_data` is all zero.
- R2: For an in-range index, bits [7:3] pick the table word and bits [2:0] pick the byte in that word. Table word w occupies bits [64w+63:64w] of `tbl_flat`, and byte b of a word sits at bits [8b+7:8b].
- R3: The count of live table bytes is (`tbl_len` + 1) * 8, so the limit is 8, 16, 24 or 32.
- R4: An index greater than or equal to the limit makes its result lane equal the same lane of `dflt_word`.
- R5: Indices are compared as unsigned 8-bit values, so any index from 32 to 255 always yields the default lane.
- R6: Lane k occupies bits [8k+7:8k] of both `idx_word` and `out_data`, and each lane is resolved independently of the other lanes.
- R7: A request is accepted when `in_valid` and `in_ready` are both high on a rising clock edge. `out_valid` is then high for exactly the next cycle, and `in_ready` is low during that cycle.
- R8: Table words at or beyond the live length never affect `out_data`.
- R9: `out_data` changes only on an accepted request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can take a request (state IDLE) |
| tbl_flat | input | 256 | Four 64-bit table words; word 0 is in the low bits |
| idx_word | input | 64 | Eight 8-bit indices |
| dflt_word | input | 64 | Default bytes for out-of-range lanes |
| tbl_len | input | 2 | Live table words minus one |
| out_valid | output | 1 | Result pulse (state RESP) |
| out_data | output | 64 | Registered lookup result |

## Verification
Four behaviours are checked on every cycle:
- the one-cycle length of the response pulse;
- the pulse following each acceptance;
- the result register holding when no request is accepted;
- any lane whose index is 32 or more carrying its default byte.

Only the directed scenarios show the rest:
- the byte mapping from index to table position;
- the exact limit for each length setting, at the last valid index and the first invalid one;
- the independence of lanes;
- the fact that inactive table words cannot leak into the result.

// File: rtl/btl_pkg.sv
package btl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } btl_state_e;
endpackage

// File: rtl/btl_lane.sv
module btl_lane #(
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 64,
    parameter int MAX_REGS = 4,
    parameter int LIM_W    = 6
) (
    input  logic [BYTE_W-1:0]          idx,
    input  logic [LIM_W-1:0]           limit,
    input  logic [MAX_REGS*WORD_W-1:0] tbl,
    input  logic [BYTE_W-1:0]          dflt_byte,
    output logic [BYTE_W-1:0]          byte_out
);
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int BSEL_W = $clog2(BYTES_PER_WORD);
    localparam int RSEL_W = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1;
    localparam int CMP_W  = (BYTE_W > LIM_W) ? BYTE_W : LIM_W;

    logic              in_range;
    logic [RSEL_W-1:0] reg_sel;
    logic [BSEL_W-1:0] byte_sel;
    logic [BYTE_W-1:0] picked;

    always_comb begin
        in_range = (CMP_W'(idx) < CMP_W'(limit));
        byte_sel = idx[BSEL_W-1:0];
        reg_sel  = idx[BSEL_W +: RSEL_W];
        picked   = tbl[(int'(reg_sel) * WORD_W) + (int'(byte_sel) * BYTE_W) +: BYTE_W];
        byte_out = in_range ? picked : dflt_byte;
    end

    // R5: any index of 32 or more must return the default lane
    always_comb begin
        if (idx >= BYTE_W'(32)) begin
            a_r5_high_idx_default : assert (byte_out == dflt_byte);
        end
    end
endmodule

// File: rtl/btl_core.sv
module btl_core #(
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 64,
    parameter int MAX_REGS = 4,
    parameter int LEN_W    = 2
) (
    input  logic [MAX_REGS*WORD_W-1:0] tbl,
    input  logic [WORD_W-1:0]          idx_word,
    input  logic [WORD_W-1:0]          dflt_word,
    input  logic [LEN_W-1:0]           tbl_len,
    output logic [WORD_W-1:0]          result
);
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int BSEL_W = $clog2(LANES);
    localparam int LIM_W  = LEN_W + 1 + BSEL_W;

    logic [LEN_W:0]     words_live;
    logic [LIM_W-1:0]   limit;

    always_comb begin
        words_live = {1'b0, tbl_len} + (LEN_W+1)'(1);
        limit      = {words_live, {BSEL_W{1'b0}}};
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        btl_lane #(
            .BYTE_W  (BYTE_W),
            .WORD_W  (WORD_W),
            .MAX_REGS(MAX_REGS),
            .LIM_W   (LIM_W)
        ) u_lane (
            .idx      (idx_word[k*BYTE_W +: BYTE_W]),
            .limit    (limit),
            .tbl      (tbl),
            .dflt_byte(dflt_word[k*BYTE_W +: BYTE_W]),
            .byte_out (result[k*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/btl_ctrl.sv
module btl_ctrl
    import btl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic out_valid,
    output logic accept
);
    btl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_RESP;   // ACCEPT, else WAIT
            ST_RESP: state_d = ST_IDLE;                 // RETIRE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_RESP);
        accept    = in_valid && (state_q == ST_IDLE);
    end

    // R7: the response pulse lasts one cycle
    a_r7_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R7: every accepted request produces a pulse next cycle
    a_r7_accept_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/byte_tbl_lookup.sv
module byte_tbl_lookup #(
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 64,
    parameter int MAX_REGS = 4,
    parameter int LEN_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [MAX_REGS*WORD_W-1:0] tbl_flat,
    input  logic [WORD_W-1:0]          idx_word,
    input  logic [WORD_W-1:0]          dflt_word,
    input  logic [LEN_W-1:0]           tbl_len,
    output logic                       out_valid,
    output logic [WORD_W-1:0]          out_data
);
    logic              accept;
    logic [WORD_W-1:0] lookup;

    btl_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .accept   (accept)
    );

    btl_core #(
        .BYTE_W  (BYTE_W),
        .WORD_W  (WORD_W),
        .MAX_REGS(MAX_REGS),
        .LEN_W   (LEN_W)
    ) u_core (
        .tbl      (tbl_flat),
        .idx_word (idx_word),
        .dflt_word(dflt_word),
        .tbl_len  (tbl_len),
        .result   (lookup)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      out_data <= '0;
        else if (accept) out_data <= lookup;
    end

    // R9: the result holds unless a request is accepted
    a_r9_hold_result : assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(out_data));
endmodule

// File: tb/tb_byte_tbl_lookup.sv
module tb_byte_tbl_lookup;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] tbl_flat = '0;
    logic [63:0]  idx_word = '0;
    logic [63:0]  dflt_word = '0;
    logic [1:0]   tbl_len = '0;
    logic         out_valid;
    logic [63:0]  out_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    byte_tbl_lookup dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .tbl_flat(tbl_flat), .idx_word(idx_word), .dflt_word(dflt_word),
        .tbl_len(tbl_len), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] model(input logic [255:0] t, input logic [63:0] ix,
                                          input logic [63:0] d, input logic [1:0] len);
        logic [63:0] r;
        int lim;
        r = '0;
        lim = (int'(len) + 1) * 8;
        for (int k = 0; k < 8; k++) begin
            int v;
            int w;
            int b;
            v = int'(ix[k*8 +: 8]);
            w = v / 8;
            b = v % 8;
            if (v < lim) r[k*8 +: 8] = t[w*64 + b*8 +: 8];
            else         r[k*8 +: 8] = d[k*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fill_table();
        for (int p = 0; p < 32; p++) tbl_flat[p*8 +: 8] = 8'(p) ^ 8'h5A;
    endtask

    // one request; checks pulse, ready low and data in the response cycle
    task automatic run_req(input string req, input logic [63:0] ix, input logic [63:0] d,
                           input logic [1:0] len);
        logic [63:0] exp;
        @(negedge clk);
        idx_word = ix; dflt_word = d; tbl_len = len; in_valid = 1'b1;
        exp = model(tbl_flat, ix, d, len);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 out_valid pulse", 64'(out_valid), 64'd1);
        check("R7 in_ready low in response", 64'(in_ready), 64'd0);
        check(req, out_data, exp);
        @(negedge clk);
        check("R7 pulse ends", 64'(out_valid), 64'd0);
    endtask

    task automatic t_reset();
        check("R1 out_valid reset", 64'(out_valid), 64'd0);
        check("R1 in_ready reset", 64'(in_ready), 64'd1);
        check("R1 out_data reset", out_data, 64'd0);
    endtask

    task automatic t_mapping();
        run_req("R2 straight indices", 64'h07060504_03020100, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3);
        run_req("R2 cross-word indices", 64'h1F_18_17_10_0F_08_01_1A, 64'h0, 2'd3);
        run_req("R6 lane independence", 64'h00_1F_00_1F_00_1F_00_1F, 64'h0, 2'd3);
    endtask

    task automatic t_limits();
        run_req("R3 len0 edge 7/8", 64'h08_07_08_07_08_07_08_07, 64'hC0C1C2C3C4C5C6C7, 2'd0);
        run_req("R3 len1 edge 15/16", 64'h10_0F_10_0F_10_0F_10_0F, 64'hC0C1C2C3C4C5C6C7, 2'd1);
        run_req("R3 len2 edge 23/24", 64'h18_17_18_17_18_17_18_17, 64'hC0C1C2C3C4C5C6C7, 2'd2);
        run_req("R4 len3 edge 31/32", 64'h20_1F_20_1F_20_1F_20_1F, 64'hC0C1C2C3C4C5C6C7, 2'd3);
        check("R4 lane 7 default byte", 64'(out_data[63:56]), 64'hC0);
    endtask

    task automatic t_high();
        run_req("R5 high indices", 64'hFF_80_21_40_E0_7F_20_FE, 64'h1122334455667788, 2'd3);
        check("R5 all default", out_data, 64'h1122334455667788);
    endtask

    task automatic t_inactive();
        logic [63:0] first;
        run_req("R8 baseline len0", 64'h0F_07_10_05_1F_02_18_00, 64'hA0A1A2A3A4A5A6A7, 2'd0);
        first = out_data;
        tbl_flat[255:64] = ~tbl_flat[255:64];
        run_req("R8 scrambled upper words", 64'h0F_07_10_05_1F_02_18_00, 64'hA0A1A2A3A4A5A6A7, 2'd0);
        check("R8 unchanged result", out_data, first);
        fill_table();
    endtask

    task automatic t_hold();
        logic [63:0] held;
        held = out_data;
        @(negedge clk);
        idx_word = ~idx_word; dflt_word = ~dflt_word; tbl_len = 2'd1;
        repeat (3) @(negedge clk);
        check("R9 result held", out_data, held);
        check("R9 no pulse", 64'(out_valid), 64'd0);
    endtask

    initial begin
        fork
            begin
                fill_table();
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_mapping();
                t_limits();
                t_high();
                t_inactive();
                t_hold();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule